// File: doc/BRIEF.md
# Converter Self-Calibration Sequencer

This block is the control core of a digital-to-analog converter. It leaves its power-on state and runs normal conversion. When the mode field of the command word is set to the calibration code, it runs two phases. The first measures offset and the second measures gain. Each phase auto-zeroes an external comparator and then samples it over several passes. The block sums the comparator outcomes and divides the sum by a power of two to form an average. It then stores each average in its own calibration register.

The command word carries three kinds of field. Two action bits clear the data word or zero both calibration registers. Three stored bits set the settling policy and decide whether the output stays attached during calibration. On every data write the block decides between fast and slow settling. The decision uses the settling policy and the size of the step. Software polls the mode field: it reads back as the normal code once calibration has finished. The first cycle after reset is the power-on state, and all writes are ignored in that cycle.

Top module: `dac_cal_sequencer`

## Requirements
- R1: After reset the outputs are as follows: mode reads 00, the data word is 0, both calibration registers are 0, fastSettle is 0 and outAttached is 1.
- R2: The mode field is cmdIn[1:0]. Writing 01 there starts calibration on the next clock. The mode then reads 01 for exactly 2*SAMPLES*PASS_LEN+1 cycles, counted from the write edge, and then reads 00 by itself. Any other value written to the mode field reads back as 00 and starts nothing.
- R3: Each calibration phase consists of SAMPLES passes of PASS_LEN cycles each. azStrobe is high in the first cycle of each pass. In every other cycle the block adds +1 if cmpIn is high and -1 if it is low. gainPhase is low in the offset phase and high in the gain phase.
- R4: The offset register receives the offset-phase sum shifted arithmetically right by SAMPLES_LOG2, sign-extended to CAL_W bits, with its most significant bit inverted.
- R5: The gain register receives the gain-phase average in the same way, but as a plain sign-extended two's-complement value with no bit inverted.
- R6: From the write that starts calibration until the mode reads 00 again, the block ignores every command write and every data write.
- R7: Writing the command word with cmdIn[2] set zeroes the data word at that clock edge. The bit is an action and is not stored.
- R8: Writing the command word with cmdIn[3] set zeroes both calibration registers at that clock edge.
- R9: Each accepted data write sets fastSettle from the stored bits cmdIn[4] (no-fast) and cmdIn[5] (all-fast). If no-fast is set, fastSettle is 0. Otherwise, if all-fast is set, fastSettle is 1. Otherwise fastSettle is 1 only if |new - old| > SMALL_STEP.
- R10: During calibration, outAttached equals the stored bit cmdIn[6]. At all other times it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| cmdWe | input | 1 | Command word write strobe |
| cmdIn | input | 7 | Command word |
| dataWe | input | 1 | Data word write strobe |
| dataIn | input | DATA_W | New data word |
| cmpIn | input | 1 | Calibration comparator result |
| modeOut | output | 2 | Mode field readback |
| dataOut | output | DATA_W | Current data word |
| offsetCal | output | CAL_W | Offset calibration register |
| gainCal | output | CAL_W | Full-scale calibration register |
| fastSettle | output | 1 | Fast settling selected for the last step |
| azStrobe | output | 1 | Comparator auto-zero pulse |
| gainPhase | output | 1 | Gain phase in progress |
| outAttached | output | 1 | Output connected to the pin |

## Verification
Most sequencer faults show up at the ports within one calibration run. A wrong pass counter or cycle counter changes how long the mode reads 01, the number of auto-zero pulses, or the stored averages. The averages are tested with three comparator patterns: the offset phase high with the gain phase low, and each level held for the whole run. A swapped or missing inversion of the top bit shows up in the register value on the cycle after the phase ends. A leak in the write lock appears as a changed data word after the run, or as a changed settling policy on the next step.

// File: rtl/dac_cal_pkg.sv
package dac_cal_pkg;

  localparam int CMD_W       = 7;
  localparam int CMD_CLR     = 2;
  localparam int CMD_CALRST  = 3;
  localparam int CMD_NOFAST  = 4;
  localparam int CMD_ALLFAST = 5;
  localparam int CMD_CONNECT = 6;

  localparam logic [1:0] MODE_NORMAL = 2'b00;
  localparam logic [1:0] MODE_CAL    = 2'b01;

  typedef enum logic [1:0] {
    ST_POWERON,
    ST_NORMAL,
    ST_CAL_OFF,
    ST_CAL_GAIN
  } seqState_t;

  typedef struct packed {
    logic accClear;
    logic accStep;
    logic storeOff;
    logic storeGain;
    logic dataLoad;
    logic dataClear;
    logic calZero;
  } dpStrobe_t;

endpackage

// File: rtl/dac_cal_ctrl.sv
module dac_cal_ctrl
  import dac_cal_pkg::*;
#(
  parameter int PASS_LEN     = 8,
  parameter int SAMPLES_LOG2 = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWe,
  input  logic [CMD_W-1:0] cmdIn,
  input  logic             dataWe,
  output dpStrobe_t        strb,
  output logic [1:0]       modeOut,
  output logic             noFast,
  output logic             allFast,
  output logic             azStrobe,
  output logic             gainPhase,
  output logic             outAttached
);

  localparam int SAMPLES = 1 << SAMPLES_LOG2;
  localparam int CYC_W   = (PASS_LEN > 1) ? $clog2(PASS_LEN) : 1;
  localparam int PASS_W  = (SAMPLES_LOG2 > 0) ? SAMPLES_LOG2 : 1;

  seqState_t         state;
  logic [1:0]        modeReg;
  logic              connect;
  logic [CYC_W-1:0]  cycCnt;
  logic [PASS_W-1:0] passCnt;

  logic inCal, lockWr, cmdAcc, passEnd, phaseEnd;

  assign inCal    = (state == ST_CAL_OFF) || (state == ST_CAL_GAIN);
  assign lockWr   = (state == ST_POWERON) || inCal || (modeReg == MODE_CAL);
  assign cmdAcc   = cmdWe && !lockWr;
  assign passEnd  = (cycCnt == CYC_W'(PASS_LEN - 1));
  assign phaseEnd = passEnd && (passCnt == PASS_W'(SAMPLES - 1));

  always_comb begin
    strb.accClear  = ((state == ST_NORMAL) && (modeReg == MODE_CAL)) ||
                     ((state == ST_CAL_OFF) && phaseEnd);
    strb.accStep   = inCal && (cycCnt != '0);
    strb.storeOff  = (state == ST_CAL_OFF) && phaseEnd;
    strb.storeGain = (state == ST_CAL_GAIN) && phaseEnd;
    strb.dataClear = cmdAcc && cmdIn[CMD_CLR];
    strb.dataLoad  = dataWe && !lockWr && !strb.dataClear;
    strb.calZero   = cmdAcc && cmdIn[CMD_CALRST];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_POWERON;
      modeReg <= MODE_NORMAL;
      noFast  <= 1'b0;
      allFast <= 1'b0;
      connect <= 1'b0;
      cycCnt  <= '0;
      passCnt <= '0;
    end else begin
      case (state)
        ST_POWERON: state <= ST_NORMAL;
        ST_NORMAL: begin
          if (cmdAcc) begin
            modeReg <= (cmdIn[1:0] == MODE_CAL) ? MODE_CAL : MODE_NORMAL;
            noFast  <= cmdIn[CMD_NOFAST];
            allFast <= cmdIn[CMD_ALLFAST];
            connect <= cmdIn[CMD_CONNECT];
          end
          if (modeReg == MODE_CAL) begin
            state   <= ST_CAL_OFF;
            cycCnt  <= '0;
            passCnt <= '0;
          end
        end
        default: begin
          cycCnt <= passEnd ? '0 : cycCnt + 1'b1;
          if (passEnd) passCnt <= passCnt + 1'b1;
          if (phaseEnd) begin
            if (state == ST_CAL_OFF) begin
              state <= ST_CAL_GAIN;
            end else begin
              state   <= ST_NORMAL;
              modeReg <= MODE_NORMAL;
            end
          end
        end
      endcase
    end
  end

  assign modeOut     = modeReg;
  assign azStrobe    = inCal && (cycCnt == '0);
  assign gainPhase   = (state == ST_CAL_GAIN);
  assign outAttached = inCal ? connect : 1'b1;

  // R2: calibration begins the cycle after the mode code is latched
  assert_cal_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_NORMAL && modeReg == MODE_CAL) |=> state == ST_CAL_OFF);

  // R2: leaving calibration always leaves the mode field at normal
  assert_mode_return_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(inCal) |-> modeReg == MODE_NORMAL);

  // R3: auto-zero lasts a single cycle per pass
  assert_az_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    azStrobe |=> !azStrobe);

  // R6: stored command bits cannot change while calibrating
  assert_cfg_locked_R6: assert property (@(posedge clk) disable iff (!rstN)
    inCal |=> $stable({noFast, allFast, connect}));

endmodule

// File: rtl/dac_cal_dp.sv
module dac_cal_dp
  import dac_cal_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int CAL_W        = 24,
  parameter int PASS_LEN     = 8,
  parameter int SAMPLES_LOG2 = 2,
  parameter int SMALL_STEP   = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              cmpIn,
  input  logic              noFast,
  input  logic              allFast,
  output logic [DATA_W-1:0] dataReg,
  output logic [CAL_W-1:0]  offReg,
  output logic [CAL_W-1:0]  gainReg,
  output logic              fastSettle
);

  localparam int ACC_W = $clog2(PASS_LEN << SAMPLES_LOG2) + 2;

  logic signed [ACC_W-1:0] acc, nextAcc, avg;
  logic [CAL_W-1:0]        avgExt;
  logic [DATA_W-1:0]       stepSize;
  logic                    bigStep, settleSel;

  assign nextAcc = acc + (cmpIn ? ACC_W'(1) : {ACC_W{1'b1}});
  assign avg     = nextAcc >>> SAMPLES_LOG2;
  assign avgExt  = {{(CAL_W - ACC_W){avg[ACC_W-1]}}, avg};

  assign stepSize  = (dataIn > dataReg) ? (dataIn - dataReg) : (dataReg - dataIn);
  assign bigStep   = stepSize > DATA_W'(SMALL_STEP);
  assign settleSel = noFast ? 1'b0 : (allFast ? 1'b1 : bigStep);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc        <= '0;
      offReg     <= '0;
      gainReg    <= '0;
      dataReg    <= '0;
      fastSettle <= 1'b0;
    end else begin
      if (strb.accClear)     acc <= '0;
      else if (strb.accStep) acc <= nextAcc;
      if (strb.calZero) begin
        offReg  <= '0;
        gainReg <= '0;
      end
      if (strb.storeOff)  offReg  <= {~avgExt[CAL_W-1], avgExt[CAL_W-2:0]};
      if (strb.storeGain) gainReg <= avgExt;
      if (strb.dataClear) dataReg <= '0;
      else if (strb.dataLoad) begin
        dataReg    <= dataIn;
        fastSettle <= settleSel;
      end
    end
  end

  // R4: a stored offset has its top two bits differing
  assert_off_format_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.storeOff |=> offReg[CAL_W-1] != offReg[CAL_W-2]);

  // R5: a stored gain keeps its sign extension intact
  assert_gain_format_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.storeGain |=> gainReg[CAL_W-1] == gainReg[CAL_W-2]);

  // R7: clearing zeroes the data word on the next cycle
  assert_data_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.dataClear |=> dataReg == '0);

  // R8: calibration reset zeroes both registers
  assert_cal_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.calZero |=> (offReg == '0 && gainReg == '0));

  // R9: disabled fast settling never selects fast
  assert_no_fast_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dataLoad && noFast) |=> !fastSettle);

endmodule

// File: rtl/dac_cal_sequencer.sv
module dac_cal_sequencer
  import dac_cal_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int CAL_W        = 24,
  parameter int PASS_LEN     = 8,
  parameter int SAMPLES_LOG2 = 2,
  parameter int SMALL_STEP   = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWe,
  input  logic [CMD_W-1:0]  cmdIn,
  input  logic              dataWe,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              cmpIn,
  output logic [1:0]        modeOut,
  output logic [DATA_W-1:0] dataOut,
  output logic [CAL_W-1:0]  offsetCal,
  output logic [CAL_W-1:0]  gainCal,
  output logic              fastSettle,
  output logic              azStrobe,
  output logic              gainPhase,
  output logic              outAttached
);

  dpStrobe_t strb;
  logic      noFast, allFast;

  dac_cal_ctrl #(
    .PASS_LEN(PASS_LEN), .SAMPLES_LOG2(SAMPLES_LOG2)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .cmdWe(cmdWe), .cmdIn(cmdIn), .dataWe(dataWe),
    .strb(strb), .modeOut(modeOut), .noFast(noFast), .allFast(allFast),
    .azStrobe(azStrobe), .gainPhase(gainPhase), .outAttached(outAttached)
  );

  dac_cal_dp #(
    .DATA_W(DATA_W), .CAL_W(CAL_W), .PASS_LEN(PASS_LEN),
    .SAMPLES_LOG2(SAMPLES_LOG2), .SMALL_STEP(SMALL_STEP)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .dataIn(dataIn), .cmpIn(cmpIn),
    .noFast(noFast), .allFast(allFast), .dataReg(dataOut),
    .offReg(offsetCal), .gainReg(gainCal), .fastSettle(fastSettle)
  );

endmodule

// File: tb/sim_dac_cal_sequencer.sv
module sim_dac_cal_sequencer;

  localparam int PERIOD   = 10;
  localparam int DATA_W   = 16;
  localparam int CAL_W    = 24;
  localparam int PASS_LEN = 8;
  localparam int SLOG2    = 2;
  localparam int SAMPLES  = 1 << SLOG2;
  localparam int CAL_CYC  = 2 * SAMPLES * PASS_LEN;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cmdWe = 1'b0;
  logic [6:0]        cmdIn = '0;
  logic              dataWe = 1'b0;
  logic [DATA_W-1:0] dataIn = '0;
  logic              cmpIn;
  int                cmpMode = 0;
  logic [1:0]        modeOut;
  logic [DATA_W-1:0] dataOut;
  logic [CAL_W-1:0]  offsetCal, gainCal;
  logic              fastSettle, azStrobe, gainPhase, outAttached;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    logic [31:0] act;
    string       tag;
  } item_t;

  item_t expQ[$];
  event  chk;

  always #(PERIOD / 2) clk = ~clk;

  assign cmpIn = (cmpMode == 0) ? 1'b1 : (cmpMode == 1) ? 1'b0 : !gainPhase;

  dac_cal_sequencer #(
    .DATA_W(DATA_W), .CAL_W(CAL_W), .PASS_LEN(PASS_LEN),
    .SAMPLES_LOG2(SLOG2), .SMALL_STEP(40)
  ) u0 (
    .clk(clk), .rstN(rstN), .cmdWe(cmdWe), .cmdIn(cmdIn), .dataWe(dataWe),
    .dataIn(dataIn), .cmpIn(cmpIn), .modeOut(modeOut), .dataOut(dataOut),
    .offsetCal(offsetCal), .gainCal(gainCal), .fastSettle(fastSettle),
    .azStrobe(azStrobe), .gainPhase(gainPhase), .outAttached(outAttached)
  );

  function automatic logic [31:0] actual(int kind);
    case (kind)
      0: return 32'(modeOut);
      1: return 32'(dataOut);
      2: return 32'(offsetCal);
      3: return 32'(gainCal);
      4: return 32'(fastSettle);
      default: return 32'(outAttached);
    endcase
  endfunction

  task automatic expectOut(int kind, logic [31:0] exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.act = '0; it.tag = tag;
    expQ.push_back(it);
    -> chk;
  endtask

  task automatic expectCount(int act, int exp, string tag);
    item_t it;
    it.kind = 6; it.exp = 32'(exp); it.act = 32'(act); it.tag = tag;
    expQ.push_back(it);
    -> chk;
  endtask

  // monitor: drains the scoreboard queue against the current outputs
  always begin
    @(chk);
    while (expQ.size() > 0) begin
      item_t it;
      logic [31:0] a;
      it = expQ.pop_front();
      a = (it.kind == 6) ? it.act : actual(it.kind);
      checks++;
      if (a !== it.exp) begin
        failures++;
        $display("FAIL %s actual=%0h expected=%0h", it.tag, a, it.exp);
      end
    end
  end

  task automatic writeCmd(logic [6:0] c);
    @(negedge clk);
    cmdIn = c; cmdWe = 1'b1;
    @(negedge clk);
    cmdWe = 1'b0;
  endtask

  task automatic writeData(logic [DATA_W-1:0] d);
    @(negedge clk);
    dataIn = d; dataWe = 1'b1;
    @(negedge clk);
    dataWe = 1'b0;
  endtask

  task automatic runCal(logic [6:0] c, int expDet, bit inject,
                        logic [CAL_W-1:0] expOff, logic [CAL_W-1:0] expGain);
    int modeCnt = 0;
    int azCnt = 0;
    int detCnt = 0;
    writeCmd(c);
    for (int i = 0; i < 400; i++) begin
      if (modeOut != 2'b01) break;
      modeCnt++;
      if (azStrobe) azCnt++;
      if (!outAttached) detCnt++;
      if (inject && i == 5) begin
        dataIn = 16'd9999; dataWe = 1'b1;
        cmdIn = 7'h10; cmdWe = 1'b1;
      end
      if (inject && i == 6) begin
        dataWe = 1'b0; cmdWe = 1'b0;
      end
      @(negedge clk);
    end
    expectCount(modeCnt, CAL_CYC + 1, "R2 mode busy cycles");
    expectCount(azCnt, 2 * SAMPLES, "R3 auto-zero pulses");
    expectCount(detCnt, expDet, "R10 detached cycles");
    expectOut(0, 32'd0, "R2 mode back to normal");
    expectOut(2, 32'(expOff), "R4 offset result");
    expectOut(3, 32'(expGain), "R5 gain result");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    expectOut(0, 32'd0, "R1 mode");
    expectOut(1, 32'd0, "R1 data");
    expectOut(2, 32'd0, "R1 offset");
    expectOut(3, 32'd0, "R1 gain");
    expectOut(4, 32'd0, "R1 settle");
    expectOut(5, 32'd1, "R1 attached");
    @(negedge clk);

    writeData(16'd100); expectOut(4, 32'd1, "R9 large step fast");
    expectOut(1, 32'd100, "R9 data loaded");
    writeData(16'd130); expectOut(4, 32'd0, "R9 small step slow");
    writeData(16'd90);  expectOut(4, 32'd0, "R9 step equal threshold");
    writeData(16'd49);  expectOut(4, 32'd1, "R9 step above threshold");
    writeCmd(7'h20);
    writeData(16'd50);  expectOut(4, 32'd1, "R9 all-fast forces fast");
    writeCmd(7'h30);
    writeData(16'd60000); expectOut(4, 32'd0, "R9 no-fast wins");
    writeCmd(7'h00);
    writeData(16'd65535); expectOut(4, 32'd1, "R9 adaptive again");
    writeCmd(7'h04);
    expectOut(1, 32'd0, "R7 clear zeroes data");
    expectOut(4, 32'd1, "R7 clear keeps settle");

    writeData(16'd1234);
    cmpMode = 0;
    runCal(7'h41, 0, 1'b1, 24'h800007, 24'h000007);
    expectOut(1, 32'd1234, "R6 data write ignored during cal");
    writeData(16'd5000);
    expectOut(4, 32'd1, "R6 no-fast write ignored during cal");

    cmpMode = 2;
    runCal(7'h01, CAL_CYC, 1'b0, 24'h800007, 24'hFFFFF9);
    cmpMode = 1;
    runCal(7'h01, CAL_CYC, 1'b0, 24'h7FFFF9, 24'hFFFFF9);

    writeCmd(7'h08);
    expectOut(2, 32'd0, "R8 offset zeroed");
    expectOut(3, 32'd0, "R8 gain zeroed");
    expectOut(1, 32'd5000, "R8 data untouched");

    writeCmd(7'h02);
    expectOut(0, 32'd0, "R2 code 10 reads normal");
    repeat (3) @(negedge clk);
    expectOut(0, 32'd0, "R2 code 10 starts nothing");
    expectOut(5, 32'd1, "R10 attached outside cal");

    #1;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule